// File: doc/BRIEF.md
# Round-Robin Pin Result Readback

A group of pin cells shares one wide readback path back to a requesting core. The path is time-multiplexed. A free-running slot counter picks one pin per clock, and the whole result word of that pin, together with its event flag, is placed on the shared path in that cycle. Successive cycles visit the pins in ascending index order and wrap back to pin 0.

A core reads a pin by raising a request with the pin's index. It keeps the request raised, with the index held steady, until the slot counter reaches that pin. In that cycle the request is accepted. On the next clock a one-cycle done pulse appears, carrying the captured word and, if the core asked for it, the pin's event flag. A core can therefore poll for an event and fetch data in one transfer.

Read latency depends on where the slot counter stands, not on the width of the data. A core that follows the rotation can read consecutive pins with no stall at all. Because the slot number is visible on a port, a core can plan its timing against it.

Top module: `pin_readback_ring`

## Requirements
- R1: While `rst` is high at a clock edge, `slot` becomes 0, and `rsp_done`, `rsp_data` and `rsp_evt` become 0.
- R2: Out of reset, `slot` rises by one on every clock. After the highest pin index (7 with the defaults) it wraps to 0.
- R3: `req_ready` is high in exactly those cycles where `req_valid` is high and `req_idx` equals `slot`.
- R4: One clock after a cycle with `req_ready` high, `rsp_done` is 1. `rsp_data` then equals the 32-bit word that pin `req_idx` presented in the accepting cycle. The word of pin i occupies bits [32*i+31 : 32*i] of `pin_words`.
- R5: `rsp_done` is 0 in every cycle that does not follow an accepting cycle. In those cycles `rsp_data` and `rsp_evt` keep their previous values.
- R6: With `req_evt` = 1 in the accepting cycle, `rsp_evt` returns bit `req_idx` of `pin_events` as sampled in that cycle. With `req_evt` = 0, `rsp_evt` is 0 even if that flag is set.
- R7: The number of stall cycles before acceptance is (index − slot at first request cycle) mod 8. This gives at most 7 stalls, and at most 8 clocks from the first request cycle to the done pulse.
- R8: If a request for the next pin in rotation order is raised in the cycle right after an acceptance, it is accepted in that cycle with zero stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_words | input | 256 | Result words of the eight pins, pin i at bits [32*i+31:32*i] |
| pin_events | input | 8 | Event flag per pin, bit i for pin i |
| req_valid | input | 1 | Read request raised; held until accepted |
| req_idx | input | 3 | Pin index requested; held steady while waiting |
| req_evt | input | 1 | Return the pin's event flag with the data |
| req_ready | output | 1 | Request accepted this cycle |
| slot | output | 3 | Pin currently driving the shared path |
| rsp_done | output | 1 | One-cycle pulse: response valid |
| rsp_data | output | 32 | Captured result word |
| rsp_evt | output | 1 | Captured event flag (0 when not requested) |

## Verification
Two things can happen in the same cycle: the done pulse of one read and the acceptance of the next. The bench provokes this with a run of requests for successive pins, each raised on the clock right after the previous acceptance. It judges the run by requiring both a fresh word from the earlier read and a zero-stall acceptance of the new one. A second overlap is covered too: a request for the pin that was just served. This is the worst case, and the bench checks that it waits the full seven stalls while the ring keeps rotating.

// File: rtl/prr_pkg.sv
package prr_pkg;
  parameter int unsigned GROUP_PINS_DEF = 8;
  parameter int unsigned WORD_W_DEF     = 32;

  function automatic int unsigned idx_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/slot_ring.sv
module slot_ring #(
  parameter int unsigned N  = prr_pkg::GROUP_PINS_DEF,
  parameter int unsigned IW = prr_pkg::idx_bits(N)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [IW-1:0] slot_o
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst)                 slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + 1'b1;
  end

  assign slot_o = slot_q;

  // R2: one step per clock, wrapping after the last pin
  assert_slot_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> slot_q == (($past(slot_q) == LAST) ? '0 : $past(slot_q) + 1'b1));
endmodule

// File: rtl/word_select.sv
module word_select #(
  parameter int unsigned N  = prr_pkg::GROUP_PINS_DEF,
  parameter int unsigned W  = prr_pkg::WORD_W_DEF,
  parameter int unsigned IW = prr_pkg::idx_bits(N)
) (
  input  logic [IW-1:0]  slot_i,
  input  logic [N*W-1:0] words_i,
  input  logic [N-1:0]   flags_i,
  output logic [W-1:0]   word_o,
  output logic           flag_o
);
  logic [N-1:0]        hit;
  logic [W-1:0]        masked [N];

  // one-hot decode of the slot, then AND-OR merge
  for (genvar g = 0; g < N; g++) begin : g_lane
    assign hit[g]    = (slot_i == IW'(g));
    assign masked[g] = hit[g] ? words_i[g*W +: W] : '0;
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < N; i++) word_o = word_o | masked[i];
    flag_o = |(flags_i & hit);
  end
endmodule

// File: rtl/read_port.sv
module read_port #(
  parameter int unsigned W  = prr_pkg::WORD_W_DEF,
  parameter int unsigned IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] slot_i,
  input  logic [W-1:0]  bus_word_i,
  input  logic          bus_flag_i,
  input  logic          req_valid_i,
  input  logic [IW-1:0] req_idx_i,
  input  logic          req_evt_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [W-1:0]  data_o,
  output logic          evt_o
);
  logic          take;
  logic          done_q;
  logic [W-1:0]  data_q;
  logic          evt_q;

  assign take    = req_valid_i && (req_idx_i == slot_i);
  assign ready_o = take;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      data_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      done_q <= take;
      if (take) begin
        data_q <= bus_word_i;
        evt_q  <= bus_flag_i & req_evt_i;
      end
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
  assign evt_o  = evt_q;

  // R4: response word is the one the shared path carried at acceptance
  assert_word_capture_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> data_o == $past(bus_word_i));

  // R5: no request, no done pulse on the next clock
  assert_no_spurious_done_R5: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> !done_o);

  // R5: outputs hold outside a done pulse
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(data_o) && $stable(evt_o)));

  // R6: event flag suppressed when not requested
  assert_evt_gate_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> evt_o == ($past(bus_flag_i) && $past(req_evt_i)));
endmodule

// File: rtl/pin_readback_ring.sv
module pin_readback_ring #(
  parameter int unsigned N  = prr_pkg::GROUP_PINS_DEF,
  parameter int unsigned W  = prr_pkg::WORD_W_DEF,
  localparam int unsigned IW = prr_pkg::idx_bits(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N*W-1:0] pin_words,
  input  logic [N-1:0]  pin_events,
  input  logic          req_valid,
  input  logic [IW-1:0] req_idx,
  input  logic          req_evt,
  output logic          req_ready,
  output logic [IW-1:0] slot,
  output logic          rsp_done,
  output logic [W-1:0]  rsp_data,
  output logic          rsp_evt
);
  logic [IW-1:0] slot_w;
  logic [W-1:0]  bus_word;
  logic          bus_flag;

  slot_ring #(.N(N), .IW(IW)) u_ring (
    .clk    (clk),
    .rst    (rst),
    .slot_o (slot_w)
  );

  word_select #(.N(N), .W(W), .IW(IW)) u_sel (
    .slot_i  (slot_w),
    .words_i (pin_words),
    .flags_i (pin_events),
    .word_o  (bus_word),
    .flag_o  (bus_flag)
  );

  read_port #(.W(W), .IW(IW)) u_port (
    .clk         (clk),
    .rst         (rst),
    .slot_i      (slot_w),
    .bus_word_i  (bus_word),
    .bus_flag_i  (bus_flag),
    .req_valid_i (req_valid),
    .req_idx_i   (req_idx),
    .req_evt_i   (req_evt),
    .ready_o     (req_ready),
    .done_o      (rsp_done),
    .data_o      (rsp_data),
    .evt_o       (rsp_evt)
  );

  assign slot = slot_w;

  // R4: an accepted request always yields a done pulse on the next clock
  assert_done_follows_R4: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> rsp_done);
endmodule

// File: tb/pin_readback_ring_tb.sv
`timescale 1ns/1ps
module pin_readback_ring_tb;
  localparam int NP = 8;
  localparam int WW = 32;
  localparam int NQ = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic [NP*WW-1:0] pin_words;
  logic [NP-1:0]   pin_events;
  logic            req_valid;
  logic [2:0]      req_idx;
  logic            req_evt;
  logic            req_ready;
  logic [2:0]      slot;
  logic            rsp_done;
  logic [WW-1:0]   rsp_data;
  logic            rsp_evt;

  always #2 clk = ~clk;

  pin_readback_ring u_dut (
    .clk(clk), .rst(rst), .pin_words(pin_words), .pin_events(pin_events),
    .req_valid(req_valid), .req_idx(req_idx), .req_evt(req_evt),
    .req_ready(req_ready), .slot(slot), .rsp_done(rsp_done),
    .rsp_data(rsp_data), .rsp_evt(rsp_evt)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // request script
  int q_idx [NQ];
  bit q_evt [NQ];
  int q_gap [NQ];
  bit q_b2b [NQ];

  logic [WW-1:0] words [NP];
  logic [NP-1:0] evts;

  task automatic drive_pins();
    for (int i = 0; i < NP; i++) begin
      words[i] = $urandom;
      pin_words[i*WW +: WW] = words[i];
    end
    evts = NP'($urandom);
    pin_events = evts;
  endtask

  initial begin
    int n;
    int mslot;
    bit exp_done, exp_evt, exp_ready;
    logic [WW-1:0] exp_data;
    bit busy;
    int cur, start, stalls, gap, qi, cyc;

    // build script
    n = 0;
    q_idx[n] = 5; q_evt[n] = 1; q_gap[n] = 0; q_b2b[n] = 0; n++;
    q_idx[n] = 5; q_evt[n] = 0; q_gap[n] = 0; q_b2b[n] = 0; n++;  // worst case
    q_idx[n] = 2; q_evt[n] = 1; q_gap[n] = 3; q_b2b[n] = 0; n++;
    for (int k = 0; k < 14; k++) begin
      q_idx[n] = (k * 3) % 8; q_evt[n] = k[0]; q_gap[n] = k % 5; q_b2b[n] = 0; n++;
    end
    for (int k = 0; k < 10; k++) begin
      q_idx[n] = k % 8; q_evt[n] = 1; q_gap[n] = 0; q_b2b[n] = (k != 0); n++;
    end
    for (int k = n; k < NQ; k++) begin
      q_idx[k] = 7 - (k % 8); q_evt[k] = 0; q_gap[k] = 1; q_b2b[k] = 0;
    end

    rst = 1'b1; req_valid = 1'b0; req_idx = '0; req_evt = 1'b0;
    drive_pins();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(slot == 0, "R1 slot", 64'(slot), 0);
    chk(rsp_done == 0, "R1 done", 64'(rsp_done), 0);
    chk(rsp_data == 0, "R1 data", 64'(rsp_data), 0);
    chk(rsp_evt == 0, "R1 evt", 64'(rsp_evt), 0);
    rst = 1'b0;

    mslot = 0; exp_done = 0; exp_evt = 0; exp_data = '0;
    busy = 0; cur = 0; start = 0; stalls = 0; qi = 0; gap = q_gap[0]; cyc = 0;

    while (qi < NQ || exp_done) begin
      // compare outputs left by the last edge
      chk(slot == 3'(mslot), "R2 slot", 64'(slot), 64'(mslot));
      chk(rsp_done == exp_done, "R4/R5 done", 64'(rsp_done), 64'(exp_done));
      chk(rsp_data == exp_data, exp_done ? "R4 data" : "R5 hold data", 64'(rsp_data), 64'(exp_data));
      chk(rsp_evt == exp_evt, "R6 evt", 64'(rsp_evt), 64'(exp_evt));

      // requester
      if (!busy && qi < NQ) begin
        if (gap > 0) gap--;
        else begin
          busy = 1; cur = qi; start = mslot; stalls = 0;
        end
      end
      req_valid = busy;
      req_idx   = busy ? 3'(q_idx[cur]) : 3'($urandom);
      req_evt   = busy ? q_evt[cur] : 1'b0;
      drive_pins();
      #1;
      exp_ready = busy && (q_idx[cur] == mslot);
      chk(req_ready == exp_ready, "R3 ready", 64'(req_ready), 64'(exp_ready));

      // model the coming edge
      exp_done = exp_ready;
      if (exp_ready) begin
        exp_data = words[q_idx[cur]];
        exp_evt  = q_evt[cur] & evts[q_idx[cur]];
        chk(stalls == ((q_idx[cur] - start) & 7), "R7 stalls", 64'(stalls), 64'((q_idx[cur] - start) & 7));
        if (q_b2b[cur]) chk(stalls == 0, "R8 zero-wait", 64'(stalls), 0);
        busy = 0; qi++;
        if (qi < NQ) gap = q_gap[qi];
      end else if (busy) begin
        stalls++;
      end
      mslot = (mslot + 1) % NP;

      @(negedge clk);
      cyc++;
      if (cyc > 5000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<=5000", cyc);
        break;
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule